// File: doc/BRIEF.md
# Transmit Byte Queue with Halt-on-NAK

This block queues the bytes a host wants to send on an I2C bus and hands them, one at a time, to the byte shifter. The host loads bytes by writing the data select of a small write port. A control write turns queue mode on or off and can discard everything held. With queue mode off, the same data write loads a single byte instead. The shifter takes a byte with a take strobe. Once the byte is on the wire, the shifter reports completion together with the acknowledge result.

When the receiving device does not acknowledge a byte, the queue stops presenting data. It records the refusal in an acknowledge flag and in an interrupt status bit. The bytes still held stay where they are until the host discards them with a flush. A separate status bit is raised when the last byte has been acknowledged and nothing remains. A sticky error bit records a data write that found no room. Each of the three status bits has a mask at the same bit position, and the interrupt line is the OR of the unmasked bits.

Top module: `i2c_txq`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_level is 0, int_status is 0, ack_nak is 0, irq is 0, tx_valid is 0, and queue mode is off.
- R2: Writes to select 0 load bytes that reach tx_data in write order. tx_valid is low while a taken byte waits for tx_done, so at most one byte is in flight.
- R3: Queue mode is off when control bit 6 (select 1) is 0. In that mode the block holds at most one byte. A data write while a byte is held or in flight is dropped and sets int_status bit 2.
- R4: With control bit 6 set, up to DEPTH bytes are held. A data write with DEPTH bytes held is dropped and sets int_status bit 2. That bit stays set until it is cleared.
- R5: tx_done with tx_nak high halts draining, so tx_valid stays 0 while the remaining bytes stay held. It also sets ack_nak to 1 and sets int_status bit 0.
- R6: Writing control bit 7 empties the queue by the next cycle and clears the halt and ack_nak. The bit is not stored, so later writes are accepted normally.
- R7: fifo_empty is 1 exactly when no byte is held and none is in flight. fifo_level counts the held bytes, not including the one in flight.
- R8: int_status bit 1 is set when tx_done with an acknowledge leaves no byte held. Taking the last byte does not set it.
- R9: Select 2 writes the interrupt masks, with bit 0 for NAK, bit 1 for empty and bit 2 for error. irq is high when any status bit and its mask are both 1.
- R10: A write to select 3 clears each int_status bit whose data bit is 1. If a new event arrives in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Write strobe |
| reg_sel | input | 2 | Write select: 0 data, 1 control, 2 masks, 3 status clear |
| reg_wdata | input | 8 | Write data |
| tx_valid | output | 1 | A byte is offered to the shifter |
| tx_data | output | 8 | Offered byte |
| tx_take | input | 1 | Shifter takes the offered byte |
| tx_done | input | 1 | Shifter finished the byte in flight |
| tx_nak | input | 1 | Receiver refused the finished byte |
| fifo_empty | output | 1 | No byte held or in flight |
| fifo_level | output | $clog2(DEPTH+1) | Held byte count |
| ack_nak | output | 1 | Result of the last finished byte, 1 for a refusal |
| int_status | output | 3 | Bit 0 NAK, bit 1 empty, bit 2 error |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, the full queue and the dropped fifth write are reached in a handful of writes, and each held byte can be followed through the halt and the flush one by one. The shifter model has an adjustable latency. This opens a window between the take of the last byte and its acknowledge, where the empty interrupt must still be low. A single injected refusal exercises the halt with bytes left behind.

// File: rtl/i2c_txq.sv
module i2c_txq #(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [7:0]                   reg_wdata,
  output logic                         tx_valid,
  output logic [7:0]                   tx_data,
  input  logic                         tx_take,
  input  logic                         tx_done,
  input  logic                         tx_nak,
  output logic                         fifo_empty,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_level,
  output logic                         ack_nak,
  output logic [2:0]                   int_status,
  output logic                         irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nxt;
  logic          q_mode, halted, busy;
  logic [2:0]    int_en, ev;

  wire data_hit = reg_we && reg_sel == 2'd0;
  wire ctl_hit  = reg_we && reg_sel == 2'd1;
  wire msk_hit  = reg_we && reg_sel == 2'd2;
  wire clr_hit  = reg_we && reg_sel == 2'd3;
  wire flush    = ctl_hit && reg_wdata[7];
  wire room     = q_mode ? (count < CW'(DEPTH)) : (count == '0 && !busy);
  wire push     = data_hit && room;
  wire pop      = tx_valid && tx_take;
  wire done_ok  = tx_done && busy && !tx_nak;
  wire done_nak = tx_done && busy && tx_nak;

  assign tx_valid   = count != '0 && !busy && !halted;
  assign tx_data    = mem[rptr];
  assign fifo_empty = count == '0 && !busy;
  assign fifo_level = count;
  assign irq        = |(int_status & int_en);
  assign count_nxt  = flush ? '0 : count + CW'(push) - CW'(pop);
  assign ev         = {data_hit && !room, done_ok && count_nxt == '0, done_nak};

  always_ff @(posedge clk) if (push) mem[wptr] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
      q_mode <= 1'b0; halted <= 1'b0; busy <= 1'b0;
      ack_nak <= 1'b0; int_status <= '0; int_en <= '0;
    end else begin
      count <= count_nxt;
      if (flush) begin
        wptr <= '0; rptr <= '0;
      end else begin
        if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
      if (ctl_hit) q_mode <= reg_wdata[6];
      if (msk_hit) int_en <= reg_wdata[2:0];
      if (pop) busy <= 1'b1;
      else if (tx_done) busy <= 1'b0;
      if (done_nak) halted <= 1'b1;
      else if (flush) halted <= 1'b0;
      if (tx_done && busy) ack_nak <= tx_nak;
      else if (flush) ack_nak <= 1'b0;
      int_status <= (int_status & ~(clr_hit ? reg_wdata[2:0] : 3'b000)) | ev;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_status[2] && !(clr_hit && reg_wdata[2]) |=> int_status[2]);
  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !tx_valid);
  assert_nak_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_nak |=> !tx_valid && ack_nak && int_status[0]);
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !done_nak |=> fifo_level == '0 && !halted && !ack_nak);
  assert_empty_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[1]) |-> $past(tx_done) && !$past(tx_nak));
endmodule

// File: tb/i2c_txq_tb.sv
module i2c_txq_tb;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic tx_valid, tx_take, tx_done, tx_nak;
  logic [7:0] tx_data;
  logic fifo_empty, ack_nak, irq;
  logic [$clog2(DEPTH+1)-1:0] fifo_level;
  logic [2:0] int_status;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];
  bit sink_on = 0, nak_next = 0, q_mode = 0;
  int sink_lat = 2;

  always #2.5 clk = ~clk;

  i2c_txq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take), .tx_done(tx_done),
    .tx_nak(tx_nak), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .ack_nak(ack_nak), .int_status(int_status), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] d);
    if (q_mode ? (exp_q.size() < DEPTH) : (exp_q.size() == 0)) exp_q.push_back(d);
    wr(2'd0, d);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // shifter model and scoreboard monitor
  initial begin
    tx_take = 1'b0; tx_done = 1'b0; tx_nak = 1'b0;
    forever begin
      @(negedge clk);
      tx_take = 1'b0; tx_done = 1'b0; tx_nak = 1'b0;
      if (sink_on && rst_n && tx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", tx_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, "R2 byte order", tx_data, e);
        end
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
        repeat (sink_lat) @(negedge clk);
        tx_done = 1'b1;
        tx_nak = nak_next;
        nak_next = 0;
      end
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    chk(fifo_level == 0 && int_status == 0, "R1 level/status", int_status, 0);
    chk(ack_nak == 0 && irq == 0 && tx_valid == 0, "R1 ack/irq/valid", tx_valid, 0);

    // R2/R7 queue mode, ordered drain
    q_mode = 1; wr(2'd1, 8'h40);
    load(8'hA1); load(8'hB2); load(8'hC3);
    settle(1);
    chk(fifo_level == 3, "R7 level", fifo_level, 3);
    chk(fifo_empty == 0, "R7 not empty", fifo_empty, 0);
    sink_on = 1;
    settle(30);
    chk(exp_q.size() == 0, "R2 all drained", exp_q.size(), 0);
    chk(fifo_empty == 1, "R7 empty after drain", fifo_empty, 1);
    chk(int_status[1] == 1, "R8 empty event", int_status[1], 1);

    // R10 clear
    wr(2'd3, 8'h07);
    chk(int_status == 0, "R10 clear", int_status, 0);

    // R8 not at take time
    sink_lat = 6;
    load(8'h5A);
    settle(3);
    chk(int_status[1] == 0, "R8 no event at take", int_status[1], 0);
    chk(fifo_empty == 0 && fifo_level == 0, "R7 in flight not empty", fifo_empty, 0);
    settle(12);
    chk(int_status[1] == 1, "R8 event on ack", int_status[1], 1);
    chk(fifo_empty == 1, "R7 empty after ack", fifo_empty, 1);
    sink_lat = 2;
    wr(2'd3, 8'h07);

    // R4 overflow
    sink_on = 0;
    for (int i = 0; i < DEPTH + 1; i++) load(8'h10 + 8'(i));
    settle(1);
    chk(fifo_level == DEPTH, "R4 full level", fifo_level, DEPTH);
    chk(int_status[2] == 1, "R4 error set", int_status[2], 1);
    settle(3);
    chk(int_status[2] == 1, "R4 error sticky", int_status[2], 1);

    // R6 flush
    wr(2'd1, 8'hC0); exp_q.delete();
    chk(fifo_level == 0 && fifo_empty == 1, "R6 flush empties", fifo_level, 0);
    load(8'h77);
    settle(1);
    chk(fifo_level == 1, "R6 flush self-clears", fifo_level, 1);
    sink_on = 1; settle(10);
    wr(2'd3, 8'h07);

    // R5 NAK halt
    sink_on = 0;
    load(8'h11); load(8'h22); load(8'h33);
    nak_next = 1; sink_on = 1;
    settle(15);
    chk(ack_nak == 1, "R5 ack bit", ack_nak, 1);
    chk(int_status[0] == 1, "R5 nak status", int_status[0], 1);
    chk(tx_valid == 0 && fifo_level == 2, "R5 held bytes", fifo_level, 2);
    chk(fifo_empty == 0, "R5 not empty", fifo_empty, 0);

    // R9 masks
    wr(2'd2, 8'h00);
    chk(irq == 0, "R9 masked", irq, 0);
    wr(2'd2, 8'h02);
    chk(irq == 0, "R9 other mask", irq, 0);
    wr(2'd2, 8'h01);
    chk(irq == 1, "R9 unmasked", irq, 1);

    // R6 flush after NAK, reuse
    sink_on = 0;
    wr(2'd1, 8'hC0); exp_q.delete();
    chk(fifo_level == 0 && ack_nak == 0, "R6 flush clears nak", ack_nak, 0);
    load(8'h99); sink_on = 1; settle(10);
    chk(exp_q.size() == 0 && fifo_empty == 1, "R6 drains after flush", exp_q.size(), 0);
    chk(ack_nak == 0, "R6 ack after reuse", ack_nak, 0);
    wr(2'd3, 8'h07);

    // R3 single-byte mode
    sink_on = 0; q_mode = 0;
    wr(2'd1, 8'h00);
    load(8'hE1); load(8'hE2);
    settle(1);
    chk(fifo_level == 1, "R3 one byte held", fifo_level, 1);
    chk(int_status[2] == 1, "R3 second write dropped", int_status[2], 1);
    sink_on = 1; settle(10);
    chk(exp_q.size() == 0 && fifo_empty == 1, "R3 single drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule